// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32768 Hz time base into a periodic event. A 4-bit rate code picks the period as a power of two of the base rate. A rate code of zero stops the divider.

Two enables decide where each event goes. The periodic-interrupt enable sends it to a flag-set strobe for the interrupt flag register. The square-wave enable sends it to a pulse output. The divider runs only when the rate code is nonzero and at least one enable is set.

The count behind the divider is a free-running 15-bit counter. It advances once for each base-rate enable and never restarts, whatever the rate code or the enables do. Each event therefore lands on a whole multiple of the selected period of that counter. A change of rate code or enables moves the next event to the next boundary of the new period.

Top module: `perIntDivider`

## Requirements
- R1: While `rstN` is low, `perEvent`, `sqwPulse` and `flagSet` are zero. Reset clears the free-running count to 0, so with rate code 3 the first event follows the 4th base tick after reset.
- R2: A rate code of 0 produces no event on any output, whichever enables are set.
- R3: For rate codes 3 to 15 the period is 2^(code−1) base ticks, for example 4 ticks for code 3 and 32 ticks for code 6. An event occurs at each tick that brings the free-running count to a multiple of the period.
- R4: Rate code 1 behaves as code 8 (period 128 ticks), and rate code 2 behaves as code 9 (period 256 ticks).
- R5: When the periodic-interrupt enable is set, each event raises `perEvent` for one cycle. In the same cycle `flagSet` is 8'hC0, which marks the summary flag at bit 7 and the periodic flag at bit 6. In every other cycle `flagSet` is 0.
- R6: When the square-wave enable is set, each event raises `sqwPulse` for one cycle. This is a pulse, not a 50% duty waveform. `sqwPulse` does not depend on the periodic-interrupt enable, and `perEvent` does not depend on the square-wave enable.
- R7: With a nonzero rate code but both enables clear, all outputs stay zero.
- R8: The count keeps advancing while the divider is stopped. After the divider is turned back on, the first event falls on the next multiple of the period of the absolute tick count, not on a count restarted at the change.
- R9: After a change of rate code, the next event is at the next multiple of the new period. No event appears at the moment of the change.
- R10: An event is visible in the clock cycle after the edge at which the boundary tick is sampled. No event occurs in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle enable at the 32768 Hz base rate |
| rateCode | input | 4 | Rate select code; 0 stops the divider |
| perIntEn | input | 1 | Periodic-interrupt enable |
| sqwEn | input | 1 | Square-wave pulse enable |
| perEvent | output | 1 | One-cycle periodic event |
| sqwPulse | output | 1 | One-cycle square-wave pulse |
| flagSet | output | 8 | Flag bits to set in this cycle (8'hC0 with an event, else 0) |

## Verification
The hardest case to reach from the ports is alignment: the phase of the hidden free-running count after the divider has been stopped, or after a rate change partway through a long period. The bench keeps its own tick count from reset, so every output cycle has a known expected value.

To reach these cases, the stimulus stops the divider for an odd number of ticks and then restarts it. It also holds code 15 for most of a 16384-tick period and then drops to code 3 before the boundary. Both sequences are compared cycle by cycle against the bench's own model.

// File: rtl/perDivPkg.sv
package perDivPkg;
  localparam int DIV_CNT_W = 15;

  typedef struct packed {
    logic                 run;
    logic [DIV_CNT_W-1:0] lowMask;
  } ctrlToDp_t;

  typedef struct packed {
    logic boundary;
  } dpToCtrl_t;
endpackage

// File: rtl/perDivDatapath.sv
module perDivDatapath
  import perDivPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  ctrlToDp_t ctrlStr,
  output dpToCtrl_t dpStr
);
  localparam int CNT_W = DIV_CNT_W;

  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] cntNext;

  assign cntNext = freeCnt + CNT_W'(1);

  // The count runs whatever the rate code or enables do.
  always_ff @(posedge clk) begin
    if (!rstN) freeCnt <= '0;
    else if (tickEn) freeCnt <= cntNext;
  end

  assign dpStr.boundary = tickEn && ctrlStr.run &&
                          ((cntNext & ctrlStr.lowMask) == '0);
endmodule

// File: rtl/perDivControl.sv
module perDivControl
  import perDivPkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int FLAG_W    = 8,
  parameter int FLAG_SET  = 8'hC0,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_ADD = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              perIntEn,
  input  logic              sqwEn,
  input  dpToCtrl_t         dpStr,
  output ctrlToDp_t         ctrlStr,
  output logic              perEvent,
  output logic              sqwPulse,
  output logic [FLAG_W-1:0] flagSet
);
  localparam int CNT_W = DIV_CNT_W;
  localparam int EXP_W = CODE_W + 1;

  logic [EXP_W-1:0] effCode;
  logic [EXP_W-1:0] shiftAmt;
  logic             codeLive;

  assign codeLive = (rateCode != '0);

  // Low codes alias upward before the period is decoded.
  always_comb begin
    if (codeLive && (rateCode <= CODE_W'(ALIAS_MAX)))
      effCode = EXP_W'(rateCode) + EXP_W'(ALIAS_ADD);
    else
      effCode = EXP_W'(rateCode);
    shiftAmt = effCode - EXP_W'(1);
  end

  assign ctrlStr.run     = codeLive && (perIntEn || sqwEn);
  assign ctrlStr.lowMask = (CNT_W'(1) << shiftAmt) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perEvent <= 1'b0;
      sqwPulse <= 1'b0;
      flagSet  <= '0;
    end else begin
      perEvent <= dpStr.boundary && perIntEn;
      sqwPulse <= dpStr.boundary && sqwEn;
      flagSet  <= (dpStr.boundary && perIntEn) ? FLAG_W'(FLAG_SET) : '0;
    end
  end
endmodule

// File: rtl/perIntDivider.sv
module perIntDivider
  import perDivPkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int FLAG_W   = 8,
  parameter int FLAG_SET = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              perIntEn,
  input  logic              sqwEn,
  output logic              perEvent,
  output logic              sqwPulse,
  output logic [FLAG_W-1:0] flagSet
);
  ctrlToDp_t ctrlStr;
  dpToCtrl_t dpStr;

  perDivDatapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .ctrlStr(ctrlStr), .dpStr(dpStr)
  );

  perDivControl #(
    .CODE_W(CODE_W), .FLAG_W(FLAG_W), .FLAG_SET(FLAG_SET)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .rateCode(rateCode),
    .perIntEn(perIntEn), .sqwEn(sqwEn), .dpStr(dpStr),
    .ctrlStr(ctrlStr), .perEvent(perEvent), .sqwPulse(sqwPulse),
    .flagSet(flagSet)
  );
endmodule

// File: rtl/perDivChk.sv
module perDivChk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic [3:0] rateCode,
  input logic       perIntEn,
  input logic       sqwEn,
  input logic       perEvent,
  input logic       sqwPulse,
  input logic [7:0] flagSet
);
  AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rateCode) == 4'd0) |-> (!perEvent && !sqwPulse)); // R2

  AST_FLAG_WITH_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    flagSet == (perEvent ? 8'hC0 : 8'h00)); // R5

  AST_EVT_NEEDS_PIE: assert property (@(posedge clk) disable iff (!rstN)
    perEvent |-> $past(perIntEn)); // R5

  AST_SQW_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    sqwPulse |-> $past(sqwEn)); // R6

  AST_SQW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sqwPulse |=> !sqwPulse); // R6

  AST_NO_EN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(perIntEn) && !$past(sqwEn)) |-> (!perEvent && !sqwPulse)); // R7

  AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (perEvent || sqwPulse) |-> $past(tickEn)); // R10
endmodule

bind perIntDivider perDivChk chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateCode(rateCode),
  .perIntEn(perIntEn), .sqwEn(sqwEn), .perEvent(perEvent),
  .sqwPulse(sqwPulse), .flagSet(flagSet)
);

// File: tb/perIntDivider_tb_top.sv
module perIntDivider_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       perIntEn = 1'b0;
  logic       sqwEn = 1'b0;
  logic       perEvent;
  logic       sqwPulse;
  logic [7:0] flagSet;

  always #5 clk = ~clk;

  perIntDivider dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateCode(rateCode),
    .perIntEn(perIntEn), .sqwEn(sqwEn), .perEvent(perEvent),
    .sqwPulse(sqwPulse), .flagSet(flagSet)
  );

  typedef struct {
    logic       p;
    logic       s;
    logic [7:0] f;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  int         checks = 0;
  int         failures = 0;
  logic [14:0] mCnt = '0;
  string      curTag = "R1";
  logic [3:0] cfgCode = 4'd0;
  logic       cfgPie = 1'b0;
  logic       cfgSqw = 1'b0;
  bit         done = 1'b0;

  function automatic logic [14:0] modelMask(input logic [3:0] c);
    int e;
    e = (c == 4'd1 || c == 4'd2) ? int'(c) + 7 : int'(c);
    return 15'((1 << (e - 1)) - 1);
  endfunction

  task automatic drive(input logic t);
    expItem_t it;
    logic [14:0] nc;
    logic hit;
    @(negedge clk);
    tickEn   = t;
    rateCode = cfgCode;
    perIntEn = cfgPie;
    sqwEn    = cfgSqw;
    nc  = mCnt + 15'd1;
    hit = t && (cfgCode != 4'd0) && (cfgPie || cfgSqw) &&
          ((nc & modelMask(cfgCode)) == 15'd0);
    it.p = hit && cfgPie;
    it.s = hit && cfgSqw;
    it.f = (hit && cfgPie) ? 8'hC0 : 8'h00;
    it.tag = curTag;
    expQ.push_back(it);
    if (t) mCnt = nc;
  endtask

  task automatic runCycles(input int n, input int every);
    for (int i = 0; i < n; i++) drive((i % every) == 0);
  endtask

  task automatic cfg(input string tg, input logic [3:0] c, input logic p, input logic s);
    curTag = tg; cfgCode = c; cfgPie = p; cfgSqw = s;
  endtask

  task automatic check1(input string tg, input logic [9:0] act, input logic [9:0] exv);
    checks++;
    if (act !== exv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exv);
    end
  endtask

  // Monitor: pops one expectation per clock, sampled after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check1(it.tag, {perEvent, sqwPulse, flagSet}, {it.p, it.s, it.f});
      end
    end
  end

  initial begin
    #1_900_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: outputs held low in reset, even with the divider set up
    rateCode = 4'd3; perIntEn = 1'b1; sqwEn = 1'b1; tickEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check1("R1", {perEvent, sqwPulse, flagSet}, 10'd0);
    end
    @(negedge clk);
    tickEn = 1'b0;
    rstN = 1'b1;
    mCnt = '0;
    cfg("R1", 4'd3, 1'b1, 1'b0);  runCycles(8, 1);
    cfg("R3", 4'd3, 1'b1, 1'b0);  runCycles(40, 1);
    cfg("R3", 4'd6, 1'b1, 1'b0);  runCycles(200, 2);
    cfg("R2", 4'd0, 1'b1, 1'b1);  runCycles(300, 1);
    cfg("R7", 4'd5, 1'b0, 1'b0);  runCycles(100, 1);
    cfg("R4", 4'd1, 1'b1, 1'b0);  runCycles(400, 1);
    cfg("R4", 4'd2, 1'b1, 1'b1);  runCycles(600, 1);
    cfg("R6", 4'd4, 1'b0, 1'b1);  runCycles(100, 1);
    cfg("R6", 4'd4, 1'b1, 1'b1);  runCycles(100, 3);
    cfg("R5", 4'd7, 1'b1, 1'b0);  runCycles(300, 1);
    cfg("R8", 4'd0, 1'b1, 1'b0);  runCycles(37, 1);
    cfg("R8", 4'd5, 1'b1, 1'b0);  runCycles(120, 1);
    cfg("R8", 4'd5, 1'b0, 1'b0);  runCycles(13, 1);
    cfg("R8", 4'd5, 1'b0, 1'b1);  runCycles(120, 1);
    cfg("R3", 4'd15, 1'b1, 1'b0); runCycles(33000, 1);
    cfg("R9", 4'd15, 1'b1, 1'b1); runCycles(9001, 1);
    cfg("R9", 4'd3, 1'b1, 1'b1);  runCycles(30, 1);
    cfg("R9", 4'd8, 1'b1, 1'b0);  runCycles(300, 1);
    cfg("R10", 4'd3, 1'b1, 1'b1); runCycles(50, 1000);
    cfg("R10", 4'd3, 1'b1, 1'b1); runCycles(120, 5);
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule